// File: doc/BRIEF.md
# DMA Channel Byte-Count Tracker

This block keeps the remaining byte count of one DMA channel's block transfer. Software loads a count over a simple write port and reads it back on `remCount`. A width input chooses a 24-bit or a 16-bit count. The block then receives a start request with a transfer size. It first confirms that the count is a whole number of transfers of that size. If so, it runs the block and takes the count down by one transfer size each time the bus engine reports a finished write address phase.

Two status bits report the outcome. A done flag rises when the count reaches zero. A configuration-error flag rises when a start is refused because the count is misaligned. Both flags hold until software writes a one to clear them. The bus engine, address generation and channel arbitration sit outside this block.

Top module: `dma_byte_tracker`

## Requirements
- R1: After reset `remCount` is zero and `busy`, `doneFlag` and `cfgErr` are low.
- R2: A count write while idle stores `regWrData[23:0]` when `wide` is 1 and `regWrData[15:0]` when `wide` is 0. Higher bits are stored as zero, and `remCount` shows the stored count masked to the current width, zero-extended.
- R3: `xferSize` encodes 00 = 4-byte longword, 01 = byte, 10 = 2-byte word, 11 = 16-byte line. While `busy`, each cycle with `wrAddrDone` high lowers `remCount` by that step, one cycle later.
- R4: `wrAddrDone` has no effect on the count while the block is idle.
- R5: An accepted start whose count is not a multiple of the step (16 for line, 4 for longword, 2 for word) sets `cfgErr`, leaves `busy` low and leaves the count unchanged.
- R6: An accepted start with a zero count sets `doneFlag` at once and never raises `busy`.
- R7: The decrement that brings the count to zero clears `busy` and sets `doneFlag` on the same edge. `busy` and `doneFlag` are never high together.
- R8: `doneFlag` and `cfgErr` are sticky. A cycle with `statusWrEn` high clears `doneFlag` if `statusWrData[0]` is 1 and clears `cfgErr` if `statusWrData[1]` is 1.
- R9: A start is ignored while `busy`, `doneFlag` or `cfgErr` is high. A flag cleared in the same cycle as a start still blocks that start.
- R10: A count write is ignored while `busy` is high, and also in any cycle where `startReq` is high.
- R11: The transfer size is captured when a block starts. Changing `xferSize` during the block does not change the decrement step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Software write strobe for the count |
| regWrData | input | 32 | Software write data for the count |
| wide | input | 1 | 1 selects a 24-bit count, 0 selects a 16-bit count |
| xferSize | input | 2 | Transfer size code (see R3) |
| startReq | input | 1 | Request to start the block transfer |
| wrAddrDone | input | 1 | A write address phase finished successfully |
| statusWrEn | input | 1 | Software write strobe for the status bits |
| statusWrData | input | 2 | Write-one-to-clear mask: bit 0 is done, bit 1 is error |
| remCount | output | 32 | Remaining byte count |
| busy | output | 1 | A block transfer is active |
| doneFlag | output | 1 | Sticky status: the block finished |
| cfgErr | output | 1 | Sticky status: a start was refused for misalignment |

## Verification
Some rules are checked by assertions on every cycle:
- each decrement equals the captured step;
- the count holds still while a block runs without write pulses, and while idle without software writes;
- `busy` and `doneFlag` are never high together, and the fall of `busy` comes with a done;
- both flags stay set until cleared;
- a set flag keeps the block from starting.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- width masking of written data;
- the mapping of each size code to its alignment rule;
- a zero-count start finishing at once;
- the size staying fixed through a block;
- writes being dropped during a block or in a start cycle.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xferSize_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } runState_e;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic loadCount;  // store the software write data
    logic armSize;    // capture the transfer size for a new block
    logic decCount;   // take one step off the count
  } ctrlStrobes_t;

endpackage

// File: rtl/bcnt_datapath.sv
module bcnt_datapath
  import bcnt_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int NARROW_W   = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wide,
  input  logic [1:0]       xferSize,
  input  logic [CNT_W-1:0] wrData,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] effCount,
  output logic [CNT_W-1:0] stepBytes,
  output logic             cntZero,
  output logic             cntAligned,
  output logic             lastBeat
);

  localparam logic [CNT_W-1:0] FULL_MASK = '1;

  logic [CNT_W-1:0] narrowMask;
  logic [CNT_W-1:0] widthMask;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] probeStep;
  xferSize_e        sizeQ;

  generate
    if (CNT_W > NARROW_W) begin : g_narrow
      assign narrowMask = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    end else begin : g_same
      assign narrowMask = FULL_MASK;
    end
  endgenerate

  function automatic logic [CNT_W-1:0] stepFor(input xferSize_e sz);
    case (sz)
      SZ_BYTE: stepFor = CNT_W'(1);
      SZ_WORD: stepFor = CNT_W'(2);
      SZ_LINE: stepFor = CNT_W'(LINE_BYTES);
      default: stepFor = CNT_W'(4);
    endcase
  endfunction

  assign widthMask = wide ? FULL_MASK : narrowMask;
  assign effCount  = countQ & widthMask;

  // The step used while running comes from the captured size.
  // The alignment probe uses the size that is live at the start request.
  assign stepBytes  = stepFor(sizeQ);
  assign probeStep  = stepFor(xferSize_e'(xferSize));
  assign cntAligned = ((effCount & (probeStep - CNT_W'(1))) == '0);
  assign cntZero    = (effCount == '0);
  assign nextCount  = (effCount - stepBytes) & widthMask;
  assign lastBeat   = (nextCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.loadCount) begin
      countQ <= wrData & widthMask;
    end else if (strobes.decCount) begin
      countQ <= nextCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ <= SZ_LONG;
    end else if (strobes.armSize) begin
      sizeQ <= xferSize_e'(xferSize);
    end
  end

endmodule

// File: rtl/bcnt_control.sv
module bcnt_control
  import bcnt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         startReq,
  input  logic         wrAddrDone,
  input  logic         statusWrEn,
  input  logic [1:0]   statusClr,
  input  logic         cntZero,
  input  logic         cntAligned,
  input  logic         lastBeat,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         doneFlag,
  output logic         cfgErr
);

  runState_e stateQ, stateD;
  logic      doneQ, doneD;
  logic      errQ, errD;
  logic      startOk;
  logic      startBad;
  logic      startEmpty;
  logic      startRun;
  logic      finishBeat;

  // A start is taken only when idle with both flags clear.
  // The flag values before this edge decide.
  assign startOk    = startReq && (stateQ == ST_IDLE) && !doneQ && !errQ;
  assign startBad   = startOk && !cntAligned;
  assign startEmpty = startOk && cntAligned && cntZero;
  assign startRun   = startOk && cntAligned && !cntZero;
  assign finishBeat = (stateQ == ST_RUN) && wrAddrDone && lastBeat;

  always_comb begin
    strobes.loadCount = regWrEn && (stateQ == ST_IDLE) && !startReq;
    strobes.armSize   = startRun;
    strobes.decCount  = (stateQ == ST_RUN) && wrAddrDone;
  end

  always_comb begin
    stateD = stateQ;
    if (startRun) begin
      stateD = ST_RUN;
    end else if (finishBeat) begin
      stateD = ST_IDLE;
    end
  end

  always_comb begin
    doneD = doneQ && !(statusWrEn && statusClr[0]);
    errD  = errQ  && !(statusWrEn && statusClr[1]);
    if (finishBeat || startEmpty) begin
      doneD = 1'b1;
    end
    if (startBad) begin
      errD = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
      errQ   <= errD;
    end
  end

  assign busy     = (stateQ == ST_RUN);
  assign doneFlag = doneQ;
  assign cfgErr   = errQ;

endmodule

// File: rtl/dma_byte_tracker.sv
module dma_byte_tracker
  import bcnt_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int CNT_W      = 24,
  parameter int NARROW_W   = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [BUS_W-1:0] regWrData,
  input  logic             wide,
  input  logic [1:0]       xferSize,
  input  logic             startReq,
  input  logic             wrAddrDone,
  input  logic             statusWrEn,
  input  logic [1:0]       statusWrData,
  output logic [BUS_W-1:0] remCount,
  output logic             busy,
  output logic             doneFlag,
  output logic             cfgErr
);

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] stepBytes;
  logic             cntZero;
  logic             cntAligned;
  logic             lastBeat;

  generate
    if (BUS_W > CNT_W) begin : g_upper
      logic unusedUpper;
      assign unusedUpper = ^regWrData[BUS_W-1:CNT_W];
    end
  endgenerate

  bcnt_datapath #(
    .CNT_W     (CNT_W),
    .NARROW_W  (NARROW_W),
    .LINE_BYTES(LINE_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wide      (wide),
    .xferSize  (xferSize),
    .wrData    (regWrData[CNT_W-1:0]),
    .strobes   (strobes),
    .effCount  (effCount),
    .stepBytes (stepBytes),
    .cntZero   (cntZero),
    .cntAligned(cntAligned),
    .lastBeat  (lastBeat)
  );

  bcnt_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .startReq  (startReq),
    .wrAddrDone(wrAddrDone),
    .statusWrEn(statusWrEn),
    .statusClr (statusWrData),
    .cntZero   (cntZero),
    .cntAligned(cntAligned),
    .lastBeat  (lastBeat),
    .strobes   (strobes),
    .busy      (busy),
    .doneFlag  (doneFlag),
    .cfgErr    (cfgErr)
  );

  assign remCount = BUS_W'(effCount);

endmodule

// File: rtl/bcnt_checker.sv
module bcnt_checker #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             wide,
  input logic             wrAddrDone,
  input logic             statusWrEn,
  input logic [1:0]       statusWrData,
  input logic             startReq,
  input logic [BUS_W-1:0] remCount,
  input logic [CNT_W-1:0] stepBytes,
  input logic             busy,
  input logic             doneFlag,
  input logic             cfgErr
);

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrAddrDone |=>
      (wide != $past(wide)) || (remCount == $past(remCount) - BUS_W'($past(stepBytes))));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !regWrEn |=> (wide != $past(wide)) || (remCount == $past(remCount)));

  p_run_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wrAddrDone |=> (wide != $past(wide)) || (remCount == $past(remCount)));

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> $past(startReq) && !busy);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(doneFlag && busy));

  p_fall_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !(statusWrEn && statusWrData[0]) |=> doneFlag);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr && !(statusWrEn && statusWrData[1]) |=> cfgErr);

  p_flag_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag || cfgErr) |=> !busy);

endmodule

bind dma_byte_tracker bcnt_checker #(
  .BUS_W(BUS_W),
  .CNT_W(CNT_W)
) u_bcnt_checker (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .wide        (wide),
  .wrAddrDone  (wrAddrDone),
  .statusWrEn  (statusWrEn),
  .statusWrData(statusWrData),
  .startReq    (startReq),
  .remCount    (remCount),
  .stepBytes   (stepBytes),
  .busy        (busy),
  .doneFlag    (doneFlag),
  .cfgErr      (cfgErr)
);

// File: tb/dma_byte_tracker_bench.sv
`timescale 1ns/1ps
module dma_byte_tracker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic        wide;
  logic [1:0]  xferSize;
  logic        startReq;
  logic        wrAddrDone;
  logic        statusWrEn;
  logic [1:0]  statusWrData;
  logic [31:0] remCount;
  logic        busy;
  logic        doneFlag;
  logic        cfgErr;

  // Reference model state
  logic [23:0] mCnt;
  logic        mBusy, mDone, mErr;
  logic [1:0]  mSize;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_byte_tracker u_dma_byte_tracker (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .wide(wide), .xferSize(xferSize), .startReq(startReq),
    .wrAddrDone(wrAddrDone), .statusWrEn(statusWrEn),
    .statusWrData(statusWrData), .remCount(remCount), .busy(busy),
    .doneFlag(doneFlag), .cfgErr(cfgErr)
  );

  function automatic logic [23:0] stepOf(input logic [1:0] sz);
    case (sz)
      2'b01:   return 24'd1;
      2'b10:   return 24'd2;
      2'b11:   return 24'd16;
      default: return 24'd4;
    endcase
  endfunction

  function automatic logic [23:0] maskOf(input logic w);
    return w ? 24'hFFFFFF : 24'h00FFFF;
  endfunction

  function automatic logic [23:0] effOf(input logic [23:0] c, input logic w);
    return c & maskOf(w);
  endfunction

  task automatic modelStep();
    logic [23:0] eff, nxt;
    logic accept, wasBusy;
    eff     = effOf(mCnt, wide);
    wasBusy = mBusy;
    accept  = startReq && !mBusy && !mDone && !mErr;
    if (statusWrEn && statusWrData[0]) mDone = 1'b0;
    if (statusWrEn && statusWrData[1]) mErr  = 1'b0;
    if (mBusy && wrAddrDone) begin
      nxt  = (eff - stepOf(mSize)) & maskOf(wide);
      mCnt = nxt;
      if (nxt == 24'd0) begin
        mBusy = 1'b0;
        mDone = 1'b1;
      end
    end else if (accept) begin
      if ((eff % stepOf(xferSize)) != 0) mErr = 1'b1;
      else if (eff == 24'd0) mDone = 1'b1;
      else begin
        mBusy = 1'b1;
        mSize = xferSize;
      end
    end
    if (regWrEn && !wasBusy && !startReq) mCnt = regWrData[23:0] & maskOf(wide);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "remCount", remCount, {8'd0, effOf(mCnt, wide)});
    check(tag, "busy", {31'd0, busy}, {31'd0, mBusy});
    check(tag, "doneFlag", {31'd0, doneFlag}, {31'd0, mDone});
    check(tag, "cfgErr", {31'd0, cfgErr}, {31'd0, mErr});
  endtask

  task automatic idleInputs();
    regWrEn = 0; regWrData = '0; startReq = 0; wrAddrDone = 0;
    statusWrEn = 0; statusWrData = '0;
  endtask

  // Inputs are driven at the falling edge. The model advances at the rising
  // edge, and the outputs are compared 1 ns after it.
  task automatic tick(input string tag);
    @(posedge clk);
    modelStep();
    #1;
    compareAll(tag);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic writeCount(input logic [31:0] d, input string tag);
    regWrEn = 1; regWrData = d; tick(tag);
  endtask

  task automatic startBlock(input logic [1:0] sz, input string tag);
    xferSize = sz; startReq = 1; tick(tag);
  endtask

  task automatic beat(input string tag);
    wrAddrDone = 1; tick(tag);
  endtask

  task automatic clearFlags(input logic [1:0] m, input string tag);
    statusWrEn = 1; statusWrData = m; tick(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    idleInputs();
    wide = 1; xferSize = 2'b01;
    rstN = 0;
    mCnt = '0; mBusy = 0; mDone = 0; mErr = 0; mSize = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1");
    rstN = 1;
    @(negedge clk);

    // R2: width masking of written data
    writeCount(32'hFFAB_CDEF, "R2");
    wide = 0;
    writeCount(32'h1234_5678, "R2");
    wide = 1;
    tick("R2");

    // R4: a write pulse while idle leaves the count alone
    beat("R4");
    beat("R4");

    // R3 and R7: a byte block of 3
    writeCount(32'd3, "R3");
    startBlock(2'b01, "R3");
    beat("R3");
    beat("R3");
    beat("R7");
    tick("R7");

    // R9: a start while done is set is ignored; a write while idle still lands
    writeCount(32'd8, "R9");
    startBlock(2'b00, "R9");
    // R9: a clear and a start in the same cycle; the start is still blocked
    statusWrEn = 1; statusWrData = 2'b01; startReq = 1; xferSize = 2'b00;
    tick("R9");

    // R5: misaligned counts for longword, word and line
    writeCount(32'd6, "R5");
    startBlock(2'b00, "R5");
    startBlock(2'b10, "R9");
    clearFlags(2'b10, "R8");
    writeCount(32'd5, "R5");
    startBlock(2'b10, "R5");
    clearFlags(2'b10, "R8");
    writeCount(32'd40, "R5");
    startBlock(2'b11, "R5");
    clearFlags(2'b01, "R8");
    clearFlags(2'b11, "R8");

    // R6: zero-count start finishes at once
    writeCount(32'd0, "R6");
    startBlock(2'b11, "R6");
    tick("R6");
    clearFlags(2'b01, "R8");

    // R10 and R11: a line block with size changes and writes during the run
    writeCount(32'd48, "R11");
    startBlock(2'b11, "R11");
    xferSize = 2'b01; beat("R11");
    writeCount(32'd4, "R10");
    xferSize = 2'b10; beat("R11");
    beat("R7");
    clearFlags(2'b01, "R8");
    // R10: a write in the same cycle as a start is dropped
    writeCount(32'd8, "R10");
    regWrEn = 1; regWrData = 32'd100; startReq = 1; xferSize = 2'b10;
    tick("R10");
    beat("R3");
    beat("R3");
    beat("R3");
    beat("R7");
    clearFlags(2'b11, "R8");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (!mBusy && ($urandom_range(0, 49) == 0)) wide = ~wide;
      regWrEn    = ($urandom_range(0, 9) == 0);
      startReq   = ($urandom_range(0, 9) == 0);
      wrAddrDone = ($urandom_range(0, 9) < 4);
      statusWrEn = ($urandom_range(0, 11) == 0);
      statusWrData = 2'($urandom);
      xferSize   = 2'($urandom);
      case ($urandom_range(0, 3))
        0: regWrData = $urandom_range(0, 48);
        1: regWrData = $urandom_range(0, 12) * 16;
        2: regWrData = $urandom_range(0, 24) * 4;
        default: regWrData = $urandom;
      endcase
      // Keep big random counts from producing very long blocks
      if (regWrData > 32'd400) regWrData = regWrData & 32'h0000_01F0;
      tick("R3");
    end

    finish();
  end

endmodule